// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor core whose call convention relies on sliding windows. At any moment the datapath sees 32 registers through a 5-bit index. Eight of them are globals, common to every procedure level. The other 24 form a window into a circular physical stack. The window has eight inputs, eight private locals and eight outputs. Neighbouring windows share storage, so the outputs of one level are physically the same cells as the inputs of the next deeper level. Arguments and return values therefore pass without any copying.

A call command moves the window one step deeper and a return command moves it back. The current window pointer is visible at a port. The block keeps its own count of the levels in use. It raises an overflow flag when a call would reuse storage that a live level still owns, and an underflow flag when a return would go past the oldest live level. A refused command leaves the pointer where it is. Spilling and filling windows to memory, and any trap handling, belong to the surrounding core.

Top module: `regwin_file`

## Requirements
- R1: Indices 0 to 7 address globals that are the same cells at every call depth: a global written at one depth reads back unchanged at another depth.
- R2: Index 0 always reads as zero on both read ports, and a write to index 0 is discarded.
- R3: Indices 16 to 23 are locals private to one level: locals written by a caller read back unchanged after a call, callee local writes and a return.
- R4: After a call, indices 24 to 31 read the values the caller left in indices 8 to 15 (same low three bits). After a return, the caller's indices 8 to 15 read what the callee left in its indices 24 to 31.
- R5: win_cmd_i = 2'b01 (call) decrements cwp_o modulo NWIN, so 0 goes to NWIN-1. 2'b10 (return) increments it modulo NWIN. 2'b00 and 2'b11 leave it unchanged. cwp_o is always below NWIN.
- R6: A call issued while NWIN-2 calls are outstanding sets ovf_o in that same cycle and leaves cwp_o unchanged. ovf_o and unf_o are never high together.
- R7: A return issued with no call outstanding sets unf_o in that same cycle and leaves cwp_o unchanged.
- R8: Reads are combinational and writes take effect at the rising clock edge. A read of the register being written in that cycle returns the old value.
- R9: Reset (rst_ni low) clears cwp_o, the outstanding-call count, both flags and every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_cmd_i | input | 2 | 01 call, 10 return, 00/11 hold |
| we_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Architectural write index |
| wr_data_i | input | XLEN | Write data |
| rd_a_idx_i | input | 5 | Read port A index |
| rd_a_data_o | output | XLEN | Read port A data |
| rd_b_idx_i | input | 5 | Read port B index |
| rd_b_data_o | output | XLEN | Read port B data |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| ovf_o | output | 1 | Call refused: window stack full |
| unf_o | output | 1 | Return refused: no live caller |

## Verification
The translation is tried with a call/write/return script over all three windowed groups and the globals. An output value set before a call must reappear as an input, and an input changed by the callee must come back as the caller's output, which separates a correct overlap direction from a mirrored one. Locals are written at two depths, so that storage shared between levels shows up as a mismatch on return. Pointer stepping is driven across the wrap from 0 to NWIN-1 and back, up to the full depth and down to empty, which tells correct flag thresholds from ones off by one in either direction.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned GRP_REGS = 8;

  typedef enum logic [1:0] {
    WIN_HOLD    = 2'b00,
    WIN_CALL    = 2'b01,
    WIN_RETURN  = 2'b10,
    WIN_INVALID = 2'b11
  } win_cmd_e;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'b00,
    GRP_OUT    = 2'b01,
    GRP_LOCAL  = 2'b10,
    GRP_IN     = 2'b11
  } arch_grp_e;
endpackage

// File: rtl/regwin_wptr.sv
module regwin_wptr
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CW = $clog2(NWIN),
  localparam int unsigned DW = $clog2(NWIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  win_cmd_e      cmd_i,
  output logic [CW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [CW-1:0] cwp_q, cwp_dn, cwp_up;
  logic [DW-1:0] depth_q;
  logic          full, empty, call_ok, ret_ok;

  assign full    = (depth_q == DW'(NWIN - 2));
  assign empty   = (depth_q == '0);
  assign call_ok = (cmd_i == WIN_CALL) && !full;
  assign ret_ok  = (cmd_i == WIN_RETURN) && !empty;
  assign ovf_o   = (cmd_i == WIN_CALL) && full;
  assign unf_o   = (cmd_i == WIN_RETURN) && empty;
  assign cwp_dn  = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - 1'b1;
  assign cwp_up  = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
  assign cwp_o   = cwp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q   <= '0;
      depth_q <= '0;
    end else if (call_ok) begin
      cwp_q   <= cwp_dn;
      depth_q <= depth_q + 1'b1;
    end else if (ret_ok) begin
      cwp_q   <= cwp_up;
      depth_q <= depth_q - 1'b1;
    end
  end

  AST_CWP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cwp_q} < (CW+1)'(NWIN)); // R5
  AST_SAVE_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == WIN_CALL && !ovf_o) |=> (cwp_q != $past(cwp_q))); // R5
  AST_DEPTH_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= DW'(NWIN - 2)); // R6
  AST_NO_OVERFLOW_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> $stable(cwp_q)); // R6
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o)); // R6
  AST_NO_UNDERFLOW_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> $stable(cwp_q)); // R7
endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CW  = $clog2(NWIN),
  localparam int unsigned PAW = $clog2(GRP_REGS + 2 * GRP_REGS * NWIN)
) (
  input  logic [4:0]     idx_i,
  input  logic [CW-1:0]  cwp_i,
  output logic [PAW-1:0] paddr_o
);
  arch_grp_e     grp_sel;
  logic [CW-1:0] cwp_dn;
  logic [PAW-1:0] grp;

  assign grp_sel = arch_grp_e'(idx_i[4:3]);
  // outs of this window are the ins of the next deeper (lower) window
  assign cwp_dn  = (cwp_i == '0) ? CW'(NWIN - 1) : cwp_i - 1'b1;

  always_comb begin
    unique case (grp_sel)
      GRP_OUT:   grp = (PAW'(cwp_dn) << 1) + PAW'(1);
      GRP_LOCAL: grp = PAW'(cwp_i) << 1;
      GRP_IN:    grp = (PAW'(cwp_i) << 1) + PAW'(1);
      default:   grp = '0;
    endcase
    if (grp_sel == GRP_GLOBAL) paddr_o = PAW'(idx_i[2:0]);
    else paddr_o = PAW'(GRP_REGS) + (grp << 3) + PAW'(idx_i[2:0]);
  end
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NPHYS = 136,
  parameter int unsigned NRD   = 2,
  localparam int unsigned PAW  = $clog2(NPHYS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PAW-1:0]  waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [PAW-1:0]  raddr_i [NRD],
  output logic [XLEN-1:0] rdata_o [NRD]
);
  logic [XLEN-1:0] mem_q [NPHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NPHYS); i++) mem_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : mem_q[raddr_i[p]];
  end
endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NWIN = 8,
  localparam int unsigned CW    = $clog2(NWIN),
  localparam int unsigned NPHYS = GRP_REGS + 2 * GRP_REGS * NWIN,
  localparam int unsigned PAW   = $clog2(NPHYS),
  localparam int unsigned NRD   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      win_cmd_i,
  input  logic            we_i,
  input  logic [4:0]      wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [4:0]      rd_a_idx_i,
  output logic [XLEN-1:0] rd_a_data_o,
  input  logic [4:0]      rd_b_idx_i,
  output logic [XLEN-1:0] rd_b_data_o,
  output logic [CW-1:0]   cwp_o,
  output logic            ovf_o,
  output logic            unf_o
);
  logic [CW-1:0]   cwp;
  logic [PAW-1:0]  waddr;
  logic [4:0]      rd_idx   [NRD];
  logic [PAW-1:0]  rd_paddr [NRD];
  logic [XLEN-1:0] rd_data  [NRD];

  initial begin
    assert (NWIN >= 3 && NWIN <= 32) else $error("NWIN out of range");
  end

  regwin_wptr #(.NWIN(NWIN)) i_wptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (win_cmd_e'(win_cmd_i)),
    .cwp_o  (cwp),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o)
  );

  // write uses the window in effect before any same-cycle move
  regwin_xlate #(.NWIN(NWIN)) i_xlate_wr (
    .idx_i   (wr_idx_i),
    .cwp_i   (cwp),
    .paddr_o (waddr)
  );

  assign rd_idx[0] = rd_a_idx_i;
  assign rd_idx[1] = rd_b_idx_i;

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd_xlate
    regwin_xlate #(.NWIN(NWIN)) i_xlate_rd (
      .idx_i   (rd_idx[p]),
      .cwp_i   (cwp),
      .paddr_o (rd_paddr[p])
    );
  end

  regwin_store #(.XLEN(XLEN), .NPHYS(NPHYS), .NRD(NRD)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (rd_paddr),
    .rdata_o (rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign cwp_o       = cwp;

  AST_G0_ZERO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == 5'd0) |-> (rd_a_data_o == '0)); // R2
  AST_G0_ZERO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_idx_i == 5'd0) |-> (rd_b_data_o == '0)); // R2
  AST_HOLD_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_cmd_i == 2'b00 || win_cmd_i == 2'b11) |=> $stable(cwp_o)); // R5
  AST_SAME_PORT_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == rd_b_idx_i) |-> (rd_a_data_o == rd_b_data_o)); // R8
endmodule

// File: tb/test_regwin_file.sv
`timescale 1ns/1ps
module test_regwin_file;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NWIN = 5;
  localparam int unsigned CW   = $clog2(NWIN);
  localparam int unsigned NVEC = 21;

  // kind: 0 write, 1 call, 2 return, 3 read and compare
  localparam logic [38:0] VEC [NVEC] = '{
    {2'd0, 5'd1,  32'h0000_0011},
    {2'd0, 5'd8,  32'h0000_00A0},
    {2'd0, 5'd16, 32'h0000_00B0},
    {2'd0, 5'd24, 32'h0000_00C0},
    {2'd3, 5'd8,  32'h0000_00A0},
    {2'd1, 5'd0,  32'h0},
    {2'd3, 5'd24, 32'h0000_00A0},
    {2'd3, 5'd1,  32'h0000_0011},
    {2'd0, 5'd16, 32'h0000_00B1},
    {2'd0, 5'd24, 32'h0000_00C1},
    {2'd0, 5'd8,  32'h0000_00A1},
    {2'd1, 5'd0,  32'h0},
    {2'd3, 5'd24, 32'h0000_00A1},
    {2'd3, 5'd16, 32'h0000_0000},
    {2'd2, 5'd0,  32'h0},
    {2'd3, 5'd16, 32'h0000_00B1},
    {2'd3, 5'd8,  32'h0000_00A1},
    {2'd2, 5'd0,  32'h0},
    {2'd3, 5'd16, 32'h0000_00B0},
    {2'd3, 5'd8,  32'h0000_00C1},
    {2'd3, 5'd24, 32'h0000_00C0}
  };
  localparam string VREQ [NVEC] = '{
    "R1", "R4", "R3", "R4", "R4", "R5", "R4", "R1", "R3", "R4", "R4",
    "R5", "R4", "R3", "R5", "R3", "R4", "R5", "R3", "R4", "R4"
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [1:0]      win_cmd_i = 2'b00;
  logic            we_i = 1'b0;
  logic [4:0]      wr_idx_i = '0;
  logic [XLEN-1:0] wr_data_i = '0;
  logic [4:0]      rd_a_idx_i = '0;
  logic [XLEN-1:0] rd_a_data_o;
  logic [4:0]      rd_b_idx_i = '0;
  logic [XLEN-1:0] rd_b_data_o;
  logic [CW-1:0]   cwp_o;
  logic            ovf_o, unf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  regwin_file #(.XLEN(XLEN), .NWIN(NWIN)) i_regwin_file (
    .clk_i, .rst_ni, .win_cmd_i, .we_i, .wr_idx_i, .wr_data_i,
    .rd_a_idx_i, .rd_a_data_o, .rd_b_idx_i, .rd_b_data_o,
    .cwp_o, .ovf_o, .unf_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs change 1 ns after a rising edge
  task automatic to_drive();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    win_cmd_i = 2'b00;
    we_i      = 1'b0;
  endtask

  task automatic do_write(logic [4:0] idx, logic [31:0] d);
    we_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
    to_drive();
    idle();
  endtask

  task automatic do_cmd(logic [1:0] c, logic exp_ovf, logic exp_unf, string req);
    win_cmd_i = c;
    #1;
    chk(req, 32'(ovf_o), 32'(exp_ovf));
    chk(req, 32'(unf_o), 32'(exp_unf));
    to_drive();
    idle();
  endtask

  task automatic rd_both(logic [4:0] idx, logic [31:0] exp, string req);
    rd_a_idx_i = idx; rd_b_idx_i = idx;
    #1;
    chk(req, rd_a_data_o, exp);
    chk(req, rd_b_data_o, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    to_drive();

    for (int v = 0; v < int'(NVEC); v++) begin
      case (VEC[v][38:37])
        2'd0: do_write(VEC[v][36:32], VEC[v][31:0]);
        2'd1: do_cmd(2'b01, 1'b0, 1'b0, VREQ[v]);
        2'd2: do_cmd(2'b10, 1'b0, 1'b0, VREQ[v]);
        default: rd_both(VEC[v][36:32], VEC[v][31:0], VREQ[v]);
      endcase
    end

    // R9: reset clears pointer, flags and registers
    rst_ni = 1'b0;
    #3 rst_ni = 1'b1;
    to_drive();
    chk("R9", 32'(cwp_o), 32'd0);
    chk("R9", 32'(ovf_o), 32'd0);
    rd_both(5'd16, 32'h0, "R9");
    rd_both(5'd1, 32'h0, "R9");

    // R2: writes to index 0 are lost
    do_write(5'd0, 32'hFFFF_FFFF);
    rd_both(5'd0, 32'h0, "R2");

    // R8: same-cycle read sees the old value
    do_write(5'd3, 32'h33);
    rd_a_idx_i = 5'd3;
    we_i = 1'b1; wr_idx_i = 5'd3; wr_data_i = 32'h44;
    #1 chk("R8", rd_a_data_o, 32'h33);
    to_drive();
    idle();
    chk("R8", rd_a_data_o, 32'h44);

    // R5: invalid command holds the pointer
    do_cmd(2'b11, 1'b0, 1'b0, "R5");
    chk("R5", 32'(cwp_o), 32'd0);

    // R5/R6: calls wrap 0 -> NWIN-1, then overflow at depth NWIN-2
    do_cmd(2'b01, 1'b0, 1'b0, "R6");
    chk("R5", 32'(cwp_o), 32'd4);
    do_cmd(2'b01, 1'b0, 1'b0, "R6");
    chk("R5", 32'(cwp_o), 32'd3);
    do_cmd(2'b01, 1'b0, 1'b0, "R6");
    chk("R5", 32'(cwp_o), 32'd2);
    do_cmd(2'b01, 1'b1, 1'b0, "R6");
    chk("R6", 32'(cwp_o), 32'd2);

    // R5/R7: returns wrap back to 0, then underflow
    do_cmd(2'b10, 1'b0, 1'b0, "R7");
    chk("R5", 32'(cwp_o), 32'd3);
    do_cmd(2'b10, 1'b0, 1'b0, "R7");
    chk("R5", 32'(cwp_o), 32'd4);
    do_cmd(2'b10, 1'b0, 1'b0, "R7");
    chk("R5", 32'(cwp_o), 32'd0);
    do_cmd(2'b10, 1'b0, 1'b1, "R7");
    chk("R7", 32'(cwp_o), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule